// File: doc/BRIEF.md
# Associative TLB with Zone Protection

This block is a fully associative translation buffer. Each slot holds a tag word, a data word and a captured process tag (TID). A lookup presents a virtual address, an access kind (read, write or fetch) and a privilege level (user or supervisor). Every valid slot is compared against the address in parallel, each slot using its own page size. Slots are further qualified by process tag and by a zone policy. The lowest-numbered qualifying slot decides the outcome, which is one of three: hit, miss or protection fault. The outcome comes with the real page number, the slot index, the page size code and the granted permissions.

Slots are loaded through a simple write port that selects either the tag word or the data word of one slot. A tag write also records the TID presented beside it. The current process ID and the 32-bit zone protection word are inputs that the lookup reads at the moment of the request. Results are registered and appear one cycle after the request strobe, together with a one-cycle done pulse.

Top module: `zone_tlb`

## Requirements
- R1: While reset is asserted and just after it, `res_done` is 0 and `res_status` is 0 (miss). Every slot is invalid after reset, so any lookup before slots are written misses.
- R2: When `wr_en` is high on a clock edge, the write port stores `wr_data` at slot `wr_idx`. With `wr_sel`=0 it goes to the tag word, and the same write records `wr_tid` as the slot's TID. With `wr_sel`=1 it goes to the data word. Lookups requested from the next edge onward see the new contents.
- R3: Tag layout: bit 6 is valid, bits 9:7 are the page size code c, and bits 31:10 hold the page number. The page size is 2^(10+2c) bytes, giving 1 KB, 4 KB, 16 KB, 64 KB, 256 KB, 1 MB, 4 MB and 16 MB. A slot's address part matches when the slot is valid and the virtual address equals the tag in all bits at or above 10+2c.
- R4: A slot whose TID is 0 matches every process. A slot with a nonzero TID matches only when its TID equals `pid`.
- R5: Data bits 7:4 hold the zone select z. The zone value is `zpr` bits [31-2z:30-2z]. The values mean:
  - 0: hides the slot from user accesses, and the search goes on past it.
  - 1: uses the slot's own permission bits.
  - 2: grants write and execute to supervisor accesses only.
  - 3: grants write and execute to every access.
  A z greater than parameter ZONE_CNT, or ZONE_EN=0, makes the value 1.
- R6: Data bit 9 is execute permission and bit 8 is write permission. Read is always granted on a match. `res_perm` reports {execute, write, read} in bits 2:0. Access codes are 0 for read, 1 for write and 2 for fetch. A write without write permission, or a fetch without execute permission, gives status 2 (fault) instead of status 1 (hit).
- R7: The lowest-index qualifying slot decides the result. `res_idx`, `res_size` (the tag size code) and `res_rpn` (data bits 31:10) come from that slot on a hit or a fault. With no qualifying slot the status is 0 (miss) and idx, size, rpn and perm are all 0.
- R8: A request on `lk_req` at a clock edge produces its result on the outputs after that edge, with `res_done` high for exactly that cycle. Without a request, `res_done` is 0 and the result outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Slot write strobe |
| wr_sel | input | 1 | 0 writes the tag word (and records the TID), 1 writes the data word |
| wr_idx | input | IDX_W | Slot index to write |
| wr_data | input | 32 | Word to store |
| wr_tid | input | TID_W | TID recorded on a tag write |
| pid | input | TID_W | Current process ID |
| zpr | input | 32 | Zone protection word, 2 bits per zone |
| lk_req | input | 1 | Lookup request strobe |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| lk_user | input | 1 | 1 for a user-mode access |
| res_done | output | 1 | One-cycle pulse when a result is presented |
| res_status | output | 2 | 0 miss, 1 hit, 2 protection fault |
| res_idx | output | IDX_W | Index of the deciding slot |
| res_rpn | output | 22 | Real page number (data bits 31:10) |
| res_size | output | 3 | Page size code of the deciding slot |
| res_perm | output | 3 | Granted permissions {execute, write, read} |

## Verification
The hardest case to reach is a slot that matches on address and TID but is passed over only because its zone hides it from user code. The search must then land on a later slot that covers the same address. The stimulus loads two 1 MB slots at the same page, one owned by process 5 and one global. It then drives a user read as process 5 with that slot's zone cleared in `zpr`. The result must come from the global slot, and the supervisor form of the same lookup must still use the first rule. Out-of-range zone selects are reached with a slot whose zone number exceeds ZONE_CNT while `zpr` grants full rights in that field.

// File: rtl/zone_tlb_pkg.sv
package zone_tlb_pkg;

    localparam int WORD_W      = 32;
    localparam int TAG_VAL_BIT = 6;
    localparam int SIZE_LSB    = 7;
    localparam int PAGE_LSB    = 10;
    localparam int DAT_EX_BIT  = 9;
    localparam int DAT_WR_BIT  = 8;
    localparam int ZSEL_LSB    = 4;
    localparam int RPN_W       = WORD_W - PAGE_LSB;

    typedef enum logic [1:0] {
        ST_MISS = 2'd0,
        ST_HIT  = 2'd1,
        ST_PROT = 2'd2
    } tlb_status_e;

    localparam logic [1:0] ACC_WRITE = 2'd1;
    localparam logic [1:0] ACC_FETCH = 2'd2;

    // Mask keeping the address bits at and above the page offset.
    function automatic logic [WORD_W-1:0] page_mask(input logic [2:0] code);
        logic [4:0] sh;
        sh = 5'd10 + {1'b0, code, 1'b0};
        return ~((32'd1 << sh) - 32'd1);
    endfunction

endpackage

// File: rtl/tlb_store.sv
module tlb_store #(
    parameter int ENTRIES = 64,
    parameter int TID_W   = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic                              wr_sel,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [zone_tlb_pkg::WORD_W-1:0]   wr_data,
    input  logic [TID_W-1:0]                  wr_tid,
    output logic [ENTRIES-1:0][zone_tlb_pkg::WORD_W-1:0] tag_o,
    output logic [ENTRIES-1:0][zone_tlb_pkg::WORD_W-1:0] data_o,
    output logic [ENTRIES-1:0][TID_W-1:0]     tid_o
);
    import zone_tlb_pkg::*;

    logic [ENTRIES-1:0][WORD_W-1:0] tag_d,  tag_q;
    logic [ENTRIES-1:0][WORD_W-1:0] data_d, data_q;
    logic [ENTRIES-1:0][TID_W-1:0]  tid_d,  tid_q;

    always_comb begin
        tag_d  = tag_q;
        data_d = data_q;
        tid_d  = tid_q;
        if (wr_en && (int'(wr_idx) < ENTRIES)) begin
            if (!wr_sel) begin
                tag_d[wr_idx] = wr_data;
                tid_d[wr_idx] = wr_tid;
            end else begin
                data_d[wr_idx] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_q  <= '0;
            data_q <= '0;
            tid_q  <= '0;
        end else begin
            tag_q  <= tag_d;
            data_q <= data_d;
            tid_q  <= tid_d;
        end
    end

    assign tag_o  = tag_q;
    assign data_o = data_q;
    assign tid_o  = tid_q;

endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int   ENTRIES  = 64,
    parameter int   TID_W    = 8,
    parameter int   ZONE_CNT = 8,
    parameter bit   ZONE_EN  = 1'b1
) (
    input  logic [ENTRIES-1:0][zone_tlb_pkg::WORD_W-1:0] tag_i,
    input  logic [ENTRIES-1:0][zone_tlb_pkg::WORD_W-1:0] data_i,
    input  logic [ENTRIES-1:0][TID_W-1:0]     tid_i,
    input  logic [zone_tlb_pkg::WORD_W-1:0]   vaddr,
    input  logic [1:0]                        acc,
    input  logic                              user,
    input  logic [TID_W-1:0]                  pid,
    input  logic [zone_tlb_pkg::WORD_W-1:0]   zpr,
    output logic [ENTRIES-1:0]                qual_o,
    output logic [ENTRIES-1:0]                deny_o,
    output logic [ENTRIES-1:0][2:0]           perm_o
);
    import zone_tlb_pkg::*;

    localparam logic [4:0] ZCNT = 5'(ZONE_CNT);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic [WORD_W-1:0] mask;
        logic              addr_ok, tid_ok, hide, ex, wr;
        logic [3:0]        zsel;
        logic [WORD_W-1:0] zshift;
        logic [1:0]        zval;
        logic              unused_low;

        assign unused_low = ^{tag_i[g][5:0], data_i[g][3:0]};

        always_comb begin
            mask    = page_mask(tag_i[g][SIZE_LSB +: 3]);
            addr_ok = tag_i[g][TAG_VAL_BIT] && (((vaddr ^ tag_i[g]) & mask) == '0);
            tid_ok  = (tid_i[g] == '0) || (tid_i[g] == pid);
            zsel    = data_i[g][ZSEL_LSB +: 4];
            zshift  = zpr >> (5'd30 - {zsel, 1'b0});
            zval    = zshift[1:0];
            if (!ZONE_EN || ({1'b0, zsel} > ZCNT)) zval = 2'd1;
            ex   = data_i[g][DAT_EX_BIT];
            wr   = data_i[g][DAT_WR_BIT];
            hide = 1'b0;
            case (zval)
                2'd0: hide = user;
                2'd2: if (!user) begin ex = 1'b1; wr = 1'b1; end
                2'd3: begin ex = 1'b1; wr = 1'b1; end
                default: ;
            endcase
            qual_o[g] = addr_ok && tid_ok && !hide;
            perm_o[g] = {ex, wr, 1'b1};
            deny_o[g] = ((acc == ACC_WRITE) && !wr) || ((acc == ACC_FETCH) && !ex);
        end
    end

endmodule

// File: rtl/tlb_prio.sv
module tlb_prio #(
    parameter int  ENTRIES = 64,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] req_i,
    output logic               found_o,
    output logic [IDX_W-1:0]   idx_o
);
    always_comb begin
        found_o = |req_i;
        idx_o   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
    end

endmodule

// File: rtl/zone_tlb.sv
module zone_tlb #(
    parameter int  ENTRIES  = 64,
    parameter int  TID_W    = 8,
    parameter int  ZONE_CNT = 8,
    parameter bit  ZONE_EN  = 1'b1,
    localparam int IDX_W    = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic [TID_W-1:0] wr_tid,
    input  logic [TID_W-1:0] pid,
    input  logic [31:0]      zpr,
    input  logic             lk_req,
    input  logic [31:0]      lk_vaddr,
    input  logic [1:0]       lk_acc,
    input  logic             lk_user,
    output logic             res_done,
    output logic [1:0]       res_status,
    output logic [IDX_W-1:0] res_idx,
    output logic [21:0]      res_rpn,
    output logic [2:0]       res_size,
    output logic [2:0]       res_perm
);
    import zone_tlb_pkg::*;

    typedef struct packed {
        logic             done;
        tlb_status_e      status;
        logic [IDX_W-1:0] idx;
        logic [RPN_W-1:0] rpn;
        logic [2:0]       size;
        logic [2:0]       perm;
    } res_t;

    logic [ENTRIES-1:0][WORD_W-1:0] tag_w, data_w;
    logic [ENTRIES-1:0][TID_W-1:0]  tid_w;
    logic [ENTRIES-1:0]             qual_w, deny_w;
    logic [ENTRIES-1:0][2:0]        perm_w;
    logic                           found_w;
    logic [IDX_W-1:0]               sel_w;
    res_t                           res_d, res_q;

    tlb_store #(.ENTRIES(ENTRIES), .TID_W(TID_W)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .wr_tid  (wr_tid),
        .tag_o   (tag_w),
        .data_o  (data_w),
        .tid_o   (tid_w)
    );

    tlb_match #(
        .ENTRIES (ENTRIES),
        .TID_W   (TID_W),
        .ZONE_CNT(ZONE_CNT),
        .ZONE_EN (ZONE_EN)
    ) match_i (
        .tag_i  (tag_w),
        .data_i (data_w),
        .tid_i  (tid_w),
        .vaddr  (lk_vaddr),
        .acc    (lk_acc),
        .user   (lk_user),
        .pid    (pid),
        .zpr    (zpr),
        .qual_o (qual_w),
        .deny_o (deny_w),
        .perm_o (perm_w)
    );

    tlb_prio #(.ENTRIES(ENTRIES)) prio_i (
        .req_i   (qual_w),
        .found_o (found_w),
        .idx_o   (sel_w)
    );

    always_comb begin
        res_d      = res_q;
        res_d.done = 1'b0;
        if (lk_req) begin
            res_d = '0;
            res_d.done = 1'b1;
            res_d.status = ST_MISS;
            if (found_w) begin
                res_d.status = deny_w[sel_w] ? ST_PROT : ST_HIT;
                res_d.idx    = sel_w;
                res_d.rpn    = data_w[sel_w][WORD_W-1:PAGE_LSB];
                res_d.size   = tag_w[sel_w][SIZE_LSB +: 3];
                res_d.perm   = perm_w[sel_w];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_done   = res_q.done;
    assign res_status = res_q.status;
    assign res_idx    = res_q.idx;
    assign res_rpn    = res_q.rpn;
    assign res_size   = res_q.size;
    assign res_perm   = res_q.perm;

endmodule

// File: rtl/zone_tlb_chk.sv
module zone_tlb_chk #(
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_req,
    input logic [1:0]       lk_acc,
    input logic             res_done,
    input logic [1:0]       res_status,
    input logic [IDX_W-1:0] res_idx,
    input logic [21:0]      res_rpn,
    input logic [2:0]       res_size,
    input logic [2:0]       res_perm
);
    // R8: result pulse follows each request, and only a request
    a_r8_done_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> res_done);
    a_r8_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !res_done);
    a_r8_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> ($stable(res_status) && $stable(res_idx) && $stable(res_rpn)
                     && $stable(res_size) && $stable(res_perm)));

    // R7: legal status, clean miss
    a_r7_legal_status: assert property (@(posedge clk) disable iff (!rst_n)
        res_status != 2'd3);
    a_r7_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (res_status == 2'd0) |-> (res_perm == 3'd0 && res_idx == '0 && res_size == 3'd0));

    // R6: read always granted; hits and faults agree with permissions
    a_r6_read_granted: assert property (@(posedge clk) disable iff (!rst_n)
        (res_status != 2'd0) |-> res_perm[0]);
    a_r6_write_hit_perm: assert property (@(posedge clk) disable iff (!rst_n)
        (res_done && res_status == 2'd1 && $past(lk_acc) == 2'd1) |-> res_perm[1]);
    a_r6_fetch_hit_perm: assert property (@(posedge clk) disable iff (!rst_n)
        (res_done && res_status == 2'd1 && $past(lk_acc) == 2'd2) |-> res_perm[2]);
    a_r6_fault_reason: assert property (@(posedge clk) disable iff (!rst_n)
        (res_done && res_status == 2'd2) |->
            (($past(lk_acc) == 2'd1 && !res_perm[1]) || ($past(lk_acc) == 2'd2 && !res_perm[2])));

endmodule

bind zone_tlb zone_tlb_chk #(.IDX_W(IDX_W)) chk_i (.*);

// File: tb/zone_tlb_tb_top.sv
module zone_tlb_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_sel = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  wr_tid = '0, pid = '0;
    logic [31:0] zpr = '0;
    logic        lk_req = 1'b0, lk_user = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [1:0]  lk_acc = '0;
    logic        res_done;
    logic [1:0]  res_status;
    logic [5:0]  res_idx;
    logic [21:0] res_rpn;
    logic [2:0]  res_size, res_perm;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    zone_tlb dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
        .wr_data(wr_data), .wr_tid(wr_tid), .pid(pid), .zpr(zpr), .lk_req(lk_req),
        .lk_vaddr(lk_vaddr), .lk_acc(lk_acc), .lk_user(lk_user), .res_done(res_done),
        .res_status(res_status), .res_idx(res_idx), .res_rpn(res_rpn),
        .res_size(res_size), .res_perm(res_perm)
    );

    typedef struct packed {
        logic [31:0] va;
        logic [1:0]  acc;
        logic        usr;
        logic [7:0]  pd;
        logic [31:0] zp;
        logic [1:0]  st;
        logic [5:0]  idx;
        logic [2:0]  perm;
        logic [2:0]  sz;
        logic [21:0] rpn;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_1ABC, 2'd0, 1'b0, 8'h00, 32'h5555_5555, 2'd1, 6'd0,  3'b011, 3'd1, 22'h200000},
        '{32'h0000_1FFF, 2'd1, 1'b1, 8'h00, 32'h5555_5555, 2'd1, 6'd0,  3'b011, 3'd1, 22'h200000},
        '{32'h0000_1004, 2'd2, 1'b0, 8'h00, 32'h5555_5555, 2'd2, 6'd0,  3'b011, 3'd1, 22'h200000},
        '{32'h0000_2000, 2'd0, 1'b0, 8'h00, 32'h5555_5555, 2'd0, 6'd0,  3'b000, 3'd0, 22'h000000},
        '{32'h004F_FFFF, 2'd0, 1'b0, 8'h05, 32'h5555_5555, 2'd1, 6'd1,  3'b101, 3'd5, 22'h240000},
        '{32'h004F_FFFF, 2'd1, 1'b0, 8'h05, 32'h5555_5555, 2'd2, 6'd1,  3'b101, 3'd5, 22'h240000},
        '{32'h0045_0000, 2'd0, 1'b0, 8'h06, 32'h5555_5555, 2'd1, 6'd2,  3'b001, 3'd5, 22'h280000},
        '{32'h0045_0000, 2'd1, 1'b0, 8'h06, 32'h5955_5555, 2'd1, 6'd2,  3'b111, 3'd5, 22'h280000},
        '{32'h0045_0000, 2'd1, 1'b1, 8'h06, 32'h5955_5555, 2'd2, 6'd2,  3'b001, 3'd5, 22'h280000},
        '{32'h0045_0000, 2'd0, 1'b1, 8'h06, 32'h5155_5555, 2'd0, 6'd0,  3'b000, 3'd0, 22'h000000},
        '{32'h0045_0000, 2'd0, 1'b0, 8'h06, 32'h5155_5555, 2'd1, 6'd2,  3'b001, 3'd5, 22'h280000},
        '{32'h0045_0000, 2'd0, 1'b1, 8'h05, 32'h4555_5555, 2'd1, 6'd2,  3'b001, 3'd5, 22'h280000},
        '{32'h01FF_FFFC, 2'd1, 1'b1, 8'h00, 32'h5555_5D55, 2'd2, 6'd3,  3'b001, 3'd7, 22'h2C0000},
        '{32'h2000_0800, 2'd0, 1'b0, 8'h00, 32'h5555_5555, 2'd0, 6'd0,  3'b000, 3'd0, 22'h000000},
        '{32'h0000_1000, 2'd2, 1'b1, 8'h00, 32'hD555_5555, 2'd1, 6'd0,  3'b111, 3'd1, 22'h200000},
        '{32'h3000_3FFF, 2'd1, 1'b0, 8'h09, 32'h5555_5555, 2'd1, 6'd63, 3'b111, 3'd2, 22'h340000},
        '{32'h2000_0400, 2'd2, 1'b1, 8'h00, 32'h5555_5555, 2'd1, 6'd5,  3'b111, 3'd0, 22'h300000}
    };

    // Tag: page number bits 31:10, size code 9:7, valid bit 6 (R3)
    function automatic logic [31:0] tagw(input logic [31:0] a, input logic [2:0] c, input logic v);
        return (a & 32'hFFFF_FC00) | (32'(c) << 7) | (32'(v) << 6);
    endfunction

    // Data: rpn 31:10, execute 9, write 8, zone select 7:4 (R5, R6)
    function automatic logic [31:0] dataw(input logic [31:0] a, input logic x, input logic w,
                                          input logic [3:0] z);
        return (a & 32'hFFFF_FC00) | (32'(x) << 9) | (32'(w) << 8) | (32'(z) << 4);
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input int idx, input logic [31:0] d, input logic [7:0] t);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_idx = 6'(idx); wr_data = d; wr_tid = t;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input logic [31:0] va, input logic [1:0] acc, input logic usr,
                        input logic [7:0] pd, input logic [31:0] zp);
        @(negedge clk);
        lk_req = 1'b1; lk_vaddr = va; lk_acc = acc; lk_user = usr; pid = pd; zpr = zp;
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "done in reset", 32'(res_done), 32'd0);
        chk("R1", "status in reset", 32'(res_status), 32'd0);
        rst_n = 1'b1;
        look(32'h0000_1000, 2'd0, 1'b0, 8'h00, 32'h5555_5555);
        chk("R1", "lookup after reset status", 32'(res_status), 32'd0);
        chk("R8", "done pulse high", 32'(res_done), 32'd1);
        @(negedge clk);
        chk("R8", "done pulse low", 32'(res_done), 32'd0);

        // Slot loading (R2)
        wr(1'b0, 0,  tagw(32'h0000_1000, 3'd1, 1'b1), 8'h00);
        wr(1'b1, 0,  dataw(32'h8000_0000, 1'b0, 1'b1, 4'd0), 8'h00);
        wr(1'b0, 1,  tagw(32'h0040_0000, 3'd5, 1'b1), 8'h05);
        wr(1'b1, 1,  dataw(32'h9000_0000, 1'b1, 1'b0, 4'd1), 8'h00);
        wr(1'b0, 2,  tagw(32'h0040_0000, 3'd5, 1'b1), 8'h00);
        wr(1'b1, 2,  dataw(32'hA000_0000, 1'b0, 1'b0, 4'd2), 8'h00);
        wr(1'b0, 3,  tagw(32'h0100_0000, 3'd7, 1'b1), 8'h00);
        wr(1'b1, 3,  dataw(32'hB000_0000, 1'b0, 1'b0, 4'd10), 8'h00);
        wr(1'b0, 5,  tagw(32'h2000_0400, 3'd0, 1'b1), 8'h00);
        wr(1'b1, 5,  dataw(32'hC000_0000, 1'b1, 1'b1, 4'd3), 8'h00);
        wr(1'b0, 10, tagw(32'h3000_0000, 3'd2, 1'b0), 8'h09);
        wr(1'b1, 10, dataw(32'hE000_0000, 1'b1, 1'b1, 4'd1), 8'h00);
        wr(1'b0, 63, tagw(32'h3000_0000, 3'd2, 1'b1), 8'h00);
        wr(1'b1, 63, dataw(32'hD000_0000, 1'b1, 1'b1, 4'd0), 8'h00);

        // Vector table: R3 size, R4 tid, R5 zones, R6 perms, R7 priority
        for (int v = 0; v < NV; v++) begin
            look(VECS[v].va, VECS[v].acc, VECS[v].usr, VECS[v].pd, VECS[v].zp);
            chk("R7", $sformatf("v%0d status", v), 32'(res_status), 32'(VECS[v].st));
            chk("R7", $sformatf("v%0d idx", v), 32'(res_idx), 32'(VECS[v].idx));
            chk("R6", $sformatf("v%0d perm", v), 32'(res_perm), 32'(VECS[v].perm));
            chk("R3", $sformatf("v%0d size", v), 32'(res_size), 32'(VECS[v].sz));
            chk("R5", $sformatf("v%0d rpn", v), 32'(res_rpn), 32'(VECS[v].rpn));
            chk("R8", $sformatf("v%0d done", v), 32'(res_done), 32'd1);
        end

        // R8: outputs hold with no request
        repeat (3) @(negedge clk);
        chk("R8", "hold done", 32'(res_done), 32'd0);
        chk("R8", "hold status", 32'(res_status), 32'd1);
        chk("R8", "hold idx", 32'(res_idx), 32'd5);

        // R2: invalidating slot 0 takes effect
        wr(1'b0, 0, tagw(32'h0000_1000, 3'd1, 1'b0), 8'h00);
        look(32'h0000_1000, 2'd0, 1'b0, 8'h00, 32'h5555_5555);
        chk("R2", "invalidated slot misses", 32'(res_status), 32'd0);

        // R2/R4: TID recorded with the tag write
        wr(1'b0, 0, tagw(32'h0000_1000, 3'd1, 1'b1), 8'h07);
        look(32'h0000_1000, 2'd0, 1'b0, 8'h07, 32'h5555_5555);
        chk("R4", "own tid hits", 32'(res_status), 32'd1);
        chk("R2", "own tid index", 32'(res_idx), 32'd0);
        look(32'h0000_1000, 2'd0, 1'b0, 8'h03, 32'h5555_5555);
        chk("R4", "other tid misses", 32'(res_status), 32'd0);

        // R3: valid bit alone blocks slot 10 even with matching tid 9 data
        look(32'h3000_0000, 2'd0, 1'b0, 8'h09, 32'h5555_5555);
        chk("R3", "invalid slot skipped", 32'(res_idx), 32'd63);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule